// File: doc/BRIEF.md
# Two-Stage Selectable Bit Encoder

This block turns a serial bit stream into the on/off control for a tag's load-modulation switch. It divides the incoming RF clock into a bit period of selectable length. It asks for each new data bit with a one-cycle request strobe. It then passes the bit through two encoders chained one after the other.

The first encoder shapes the bit in time. It can pass the bit straight through, or apply a mid-bit transition code (Manchester) or a transition-at-every-boundary code (biphase). The second encoder puts the result onto the RF clock in one of three ways: directly, as a phase-reversing square-wave carrier (three reversal rules), or as a square wave whose frequency depends on the level (four frequency pairs).

All selects are static configuration inputs. A controller changes them only while the block is held in reset.

Top module: `two_stage_encoder`

## Requirements
- R1: While `rst` is high, `mod_out` and `bit_req` are both low, whatever the data and configuration inputs are.
- R2: `bit_req` is a single-cycle pulse that recurs every N clocks. N is 8, 16, 32, 40, 50, 64, 100 or 128 for `rate_sel` codes 0 to 7.
- R3: `din` is captured at the clock edge that ends a `bit_req` cycle. Position k (0 to N-1) of that bit appears on `mod_out` in the cycle after clock edge k+1 following the capture. With `enc1_sel`=00 and `enc2_sel`=000 the output equals the bit for the whole period.
- R4: With `enc1_sel`=01 (Manchester), positions below N/2 carry the inverse of the bit and the rest carry the bit. A 1 is therefore a rising mid-bit edge and a 0 a falling one.
- R5: With `enc1_sel`=10 (biphase), the level inverts at every bit start, and a 1 adds one inversion at position N/2. The level is low during the first bit period after reset.
- R6: `enc1_sel`=11 behaves exactly like 00.
- R7: The carrier period C is 2, 4, 8 and 8 clocks for `car_sel` codes 0 to 3. When C divides N, the carrier restarts at each bit start. In that case, with no phase reversal, position k is high when (k mod C) >= C/2.
- R8: `enc2_sel`=001 reverses the carrier phase in every cycle where the first-stage level differs from its value in the previous cycle.
- R9: `enc2_sel`=010 reverses the carrier phase at position 0 of every bit whose first-stage level there is high.
- R10: `enc2_sel`=011 reverses the carrier phase only on a low-to-high change of the first-stage level.
- R11: Codes 100 to 111 of `enc2_sel` select a square wave of period P that restarts at each bit start. P is chosen as follows, for level 1 / level 0: 100 gives 5/8, 101 gives 10/8, 110 gives 8/5 and 111 gives 8/10. Position k is high when (k mod P) < ceil(P/2).
- R12: When C does not divide N, the carrier runs on without restarting across bit boundaries. With steady data, `mod_out` is then a square wave of period C with no phase jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, presented in response to `bit_req` |
| rate_sel | input | 3 | Bit-period divisor select |
| enc1_sel | input | 2 | First-stage code select |
| enc2_sel | input | 3 | Second-stage code select |
| car_sel | input | 2 | Phase-reversal carrier period select |
| bit_req | output | 1 | One-cycle request for the next data bit |
| mod_out | output | 1 | Load-modulation control |

## Verification
The hardest case to reach from the ports is a bit period that the carrier or the frequency-shift period does not divide evenly. Only there does the choice between restarting and free-running show up, and it shows only at the boundary cycles. The stimulus pairs a 50-clock bit with a 4-clock carrier and checks that the square wave runs on unbroken across boundaries. It also pairs 16-clock bits with 5- and 10-clock frequency periods, where a correct restart produces a visibly truncated last cycle before each boundary.

// File: rtl/two_stage_encoder.sv
module two_stage_encoder (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [2:0] rate_sel,
  input  logic [1:0] enc1_sel,
  input  logic [2:0] enc2_sel,
  input  logic [1:0] car_sel,
  output logic       bit_req,
  output logic       mod_out
);

  logic [6:0] cnt, last, half;
  logic [2:0] pc, pcv, car_last, car_half;
  logic [3:0] fc, fcv, f_last, f_high;
  logic cur_bit, bp_lvl, lvl1, lvl1_q, ph, ph_now, flip;
  logic car, fsk, alt, mod_next;

  always_comb begin
    case (rate_sel)
      3'd0: last = 7'd7;
      3'd1: last = 7'd15;
      3'd2: last = 7'd31;
      3'd3: last = 7'd39;
      3'd4: last = 7'd49;
      3'd5: last = 7'd63;
      3'd6: last = 7'd99;
      default: last = 7'd127;
    endcase
  end

  assign half      = (last >> 1) + 7'd1;
  assign bit_req   = cnt >= last;
  wire   bit_start = cnt == 7'd0;
  wire   second    = cnt >= half;

  // first stage
  always_comb begin
    case (enc1_sel)
      2'b01:   lvl1 = second ? cur_bit : ~cur_bit;
      2'b10:   lvl1 = bp_lvl ^ (cur_bit & second);
      default: lvl1 = cur_bit;
    endcase
  end

  // phase-reversal carrier
  always_comb begin
    case (car_sel)
      2'd0:    begin car_last = 3'd1; car_half = 3'd1; end
      2'd1:    begin car_last = 3'd3; car_half = 3'd2; end
      default: begin car_last = 3'd7; car_half = 3'd4; end
    endcase
  end

  wire aligned = (last[2:0] & car_last) == car_last;
  assign pcv = (bit_start && aligned) ? 3'd0 : pc;
  assign car = pcv >= car_half;

  always_comb begin
    case (enc2_sel)
      3'd1:    flip = lvl1 ^ lvl1_q;
      3'd2:    flip = bit_start & lvl1;
      3'd3:    flip = lvl1 & ~lvl1_q;
      default: flip = 1'b0;
    endcase
  end
  assign ph_now = ph ^ flip;

  // frequency shift
  assign alt = lvl1 ^ enc2_sel[1];
  always_comb begin
    if (!alt)             begin f_last = 4'd7; f_high = 4'd4; end
    else if (enc2_sel[0]) begin f_last = 4'd9; f_high = 4'd5; end
    else                  begin f_last = 4'd4; f_high = 4'd3; end
  end
  assign fcv = bit_start ? 4'd0 : fc;
  assign fsk = fcv < f_high;

  always_comb begin
    case (enc2_sel)
      3'd0:                mod_next = lvl1;
      3'd1, 3'd2, 3'd3:    mod_next = car ^ ph_now;
      default:             mod_next = fsk;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; cur_bit <= 1'b0; bp_lvl <= 1'b0; lvl1_q <= 1'b0;
      ph <= 1'b0; pc <= '0; fc <= '0; mod_out <= 1'b0;
    end else begin
      cnt <= bit_req ? 7'd0 : cnt + 7'd1;
      if (bit_req) begin
        cur_bit <= din;
        bp_lvl  <= ~(bp_lvl ^ cur_bit);
      end
      lvl1_q  <= lvl1;
      ph      <= ph_now;
      pc      <= (pcv == car_last) ? 3'd0 : pcv + 3'd1;
      fc      <= (fcv >= f_last) ? 4'd0 : fcv + 4'd1;
      mod_out <= mod_next;
    end
  end

  p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
    bit_req |=> !bit_req);
  p_req_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    bit_req |=> cnt == 7'd0);
  p_direct_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (enc1_sel == 2'b00 && enc2_sel == 3'd0) |=> mod_out == $past(cur_bit));
  p_manch_mid_r4: assert property (@(posedge clk) disable iff (rst)
    (enc1_sel == 2'b01 && $past(enc1_sel) == 2'b01 && $stable(rate_sel) && cnt == half)
      |-> lvl1 != lvl1_q);
  p_fsk_restart_r11: assert property (@(posedge clk) disable iff (rst)
    (enc2_sel[2] && bit_start) |=> mod_out);

endmodule

// File: tb/sim_two_stage_encoder.sv
module sim_two_stage_encoder;
  localparam int TCK = 10;
  localparam int NV  = 17;
  // {rate, enc1, enc2, car, pattern}
  localparam logic [17:0] VECS [NV] = '{
    {3'd0, 2'd0, 3'd0, 2'd0, 8'hB2},  // R3
    {3'd3, 2'd0, 3'd0, 2'd0, 8'h5C},  // R3
    {3'd0, 2'd1, 3'd0, 2'd0, 8'hCA},  // R4
    {3'd4, 2'd1, 3'd0, 2'd0, 8'h39},  // R4
    {3'd1, 2'd2, 3'd0, 2'd0, 8'h9D},  // R5
    {3'd6, 2'd2, 3'd0, 2'd0, 8'hA6},  // R5
    {3'd0, 2'd3, 3'd0, 2'd0, 8'h6B},  // R6
    {3'd1, 2'd0, 3'd1, 2'd1, 8'hB4},  // R8
    {3'd3, 2'd0, 3'd1, 2'd2, 8'h71},  // R8
    {3'd0, 2'd0, 3'd2, 2'd0, 8'hD9},  // R9
    {3'd2, 2'd0, 3'd3, 2'd1, 8'h8F},  // R10
    {3'd1, 2'd1, 3'd1, 2'd0, 8'h2E},  // R8 fed by Manchester
    {3'd3, 2'd0, 3'd4, 2'd0, 8'hC5},  // R11
    {3'd1, 2'd0, 3'd5, 2'd0, 8'h5A},  // R11
    {3'd1, 2'd0, 3'd6, 2'd0, 8'h93},  // R11
    {3'd2, 2'd0, 3'd7, 2'd0, 8'h3C},  // R11
    {3'd3, 2'd0, 3'd1, 2'd3, 8'hE2}   // R7
  };

  logic clk = 0, rst = 1, din = 0;
  logic [2:0] rate_sel = 0, enc2_sel = 0;
  logic [1:0] enc1_sel = 0, car_sel = 0;
  logic bit_req, mod_out;
  int total = 0, bad = 0;
  logic got [1024];
  logic expv [1024];
  logic m_lvl, m_prev, m_ph;

  two_stage_encoder u0 (.clk, .rst, .din, .rate_sel, .enc1_sel, .enc2_sel,
                        .car_sel, .bit_req, .mod_out);

  always #(TCK/2) clk = ~clk;

  function automatic int div_val(logic [2:0] r);
    case (r)
      3'd0: return 8;   3'd1: return 16;  3'd2: return 32;  3'd3: return 40;
      3'd4: return 50;  3'd5: return 64;  3'd6: return 100; default: return 128;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] a, logic [2:0] b, logic [1:0] c);
    if (b == 0) begin
      case (a) 2'd0: return "R3"; 2'd1: return "R4"; 2'd2: return "R5"; default: return "R6"; endcase
    end
    if (b < 4 && c == 3) return "R7";
    if (b == 1) return "R8";
    if (b == 2) return "R9";
    if (b == 3) return "R10";
    return "R11";
  endfunction

  task automatic model_bit(input logic b, input int base, input bit store, input int dv);
    int cp, pp;
    logic s, fl, e;
    cp = (car_sel == 0) ? 2 : (car_sel == 1) ? 4 : 8;
    for (int k = 0; k < dv; k++) begin
      if (enc1_sel == 2'd1) s = (k >= dv/2) ? b : ~b;
      else if (enc1_sel == 2'd2) s = (k >= dv/2) ? (m_lvl ^ b) : m_lvl;
      else s = b;
      case (enc2_sel)
        3'd1: fl = s != m_prev;
        3'd2: fl = (k == 0) && s;
        3'd3: fl = s && !m_prev;
        default: fl = 0;
      endcase
      m_ph = m_ph ^ fl;
      if (enc2_sel == 0) e = s;
      else if (enc2_sel < 4) e = (((k % cp) >= cp/2) ? 1'b1 : 1'b0) ^ m_ph;
      else begin
        case (enc2_sel)
          3'd4: pp = s ? 5 : 8;
          3'd5: pp = s ? 10 : 8;
          3'd6: pp = s ? 8 : 5;
          default: pp = s ? 8 : 10;
        endcase
        e = (k % pp) < (pp + 1) / 2;
      end
      if (store) expv[base + k] = e;
      m_prev = s;
    end
    if (enc1_sel == 2'd2) m_lvl = ~(m_lvl ^ b);
  endtask

  task automatic run_stream(input logic [7:0] pat, input int dv);
    int nb;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    while (!bit_req) @(negedge clk);
    din = pat[7];
    nb = 1;
    @(negedge clk);
    for (int j = 0; j < dv * 8; j++) begin
      @(negedge clk);
      got[j] = mod_out;
      if (bit_req && nb < 8) begin
        din = pat[7 - nb];
        nb++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [17:0] v;
    logic [7:0] pat;
    int dv, pulses, gap;
    bit ok;

    // R1: reset holds outputs low even with Manchester (idle level high)
    enc1_sel = 2'd1; din = 1;
    repeat (5) @(negedge clk);
    total++;
    if (mod_out !== 1'b0 || bit_req !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got mod=%b req=%b exp mod=0 req=0", mod_out, bit_req);
    end

    // R2: request spacing for every rate code
    enc1_sel = 0; din = 0;
    for (int r = 0; r < 8; r++) begin
      rate_sel = 3'(r);
      dv = div_val(rate_sel);
      rst = 1; repeat (2) @(negedge clk); rst = 0;
      @(negedge clk);
      while (!bit_req) @(negedge clk);
      gap = 0; pulses = 0;
      @(negedge clk); gap++;
      if (bit_req) pulses++;
      while (!bit_req) begin @(negedge clk); gap++; end
      total++;
      if (gap != dv || pulses != 0) begin
        bad++;
        $display("FAIL R2 rate %0d: got gap=%0d wide=%0d exp gap=%0d wide=0", r, gap, pulses, dv);
      end
    end

    // main vector table
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      rate_sel = v[17:15]; enc1_sel = v[14:13]; enc2_sel = v[12:10];
      car_sel = v[9:8]; pat = v[7:0];
      dv = div_val(rate_sel);
      run_stream(pat, dv);
      m_lvl = 0; m_prev = 0; m_ph = 0;
      model_bit(1'b0, 0, 1'b0, dv);
      for (int b = 0; b < 8; b++) model_bit(pat[7 - b], b * dv, 1'b1, dv);
      for (int b = 0; b < 8; b++) begin
        ok = 1;
        total++;
        for (int k = 0; k < dv; k++) begin
          if (ok && got[b*dv + k] !== expv[b*dv + k]) begin
            ok = 0; bad++;
            $display("FAIL %s vec %0d bit %0d pos %0d: got %b exp %b",
                     tag_of(enc1_sel, enc2_sel, car_sel), i, b, k,
                     got[b*dv + k], expv[b*dv + k]);
          end
        end
      end
    end

    // R12: 4-clock carrier over 50-clock bits runs on without a phase jump
    rate_sel = 3'd4; enc1_sel = 0; enc2_sel = 3'd1; car_sel = 2'd1;
    dv = 50;
    run_stream(8'h00, dv);
    ok = 1;
    total++;
    for (int j = 2; j < dv * 8; j++) begin
      if (ok && got[j] !== ~got[j-2]) begin
        ok = 0; bad++;
        $display("FAIL R12 sample %0d: got %b exp %b", j, got[j], ~got[j-2]);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule